// File: doc/BRIEF.md
# Add/Subtract/Shift Unit with Stored Condition Flags

This block is the integer arithmetic slice of a datapath. In one clock it adds or subtracts two 32-bit operands, or shifts the first operand right logically by a 5-bit amount. It also produces the four condition flags: negative (N), zero (Z), carry (C) and overflow (V). The result word and the result-valid indication are combinational. The flags live in a small register that changes at a rising clock edge only when the caller raises the set-flags enable. Later logic, such as branch condition evaluation, reads the stored flags.

Subtraction reuses the adder. The second operand is inverted and a carry of 1 enters the lowest column. The same adder therefore serves signed and unsigned operands, and after a subtract the carry means "no borrow". Overflow comes from the carries into and out of the top bit. A compare is a subtract that updates the flags but does not mark its result as valid. A shift leaves overflow untouched and puts the last bit it shifted out into carry.

Top module: `asu_nzcv`

## Requirements
- R1: With op_i = 0 (add), result_o equals (a_i + b_i) mod 2^32. When flags are set, C takes the carry out of bit 31.
- R2: With op_i = 1 (subtract), result_o equals (a_i − b_i) mod 2^32, computed as a_i + ~b_i + 1. When flags are set, C becomes 1 exactly when a_i ≥ b_i as unsigned values.
- R3: For add, subtract and compare, V is set to 1 exactly when the two's-complement result is outside [−2^31, 2^31−1]. This is the case where the operand signs agree (with b inverted for subtraction) and the result sign differs from them.
- R4: On every flag update, N takes bit 31 of the operation's result word. Z becomes 1 exactly when all 32 result bits are zero.
- R5: With op_i = 2 (compare), the flags update as for a subtract and result_valid_o is 0. For every other op_i, result_valid_o is 1.
- R6: With op_i = 3 (logical right shift), result_o is a_i shifted right by shamt_i with zeros filled in. When flags are set, C takes bit a_i[shamt_i−1] and V keeps its stored value.
- R7: A shift with shamt_i = 0 returns a_i unchanged and leaves C at its stored value.
- R8: While set_flags_i is 0, all four flag outputs keep their values across the clock edge, whatever the operation.
- R9: While rst_ni is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 32 | First operand, also the shifted operand |
| b_i | input | 32 | Second operand |
| op_i | input | 2 | 0 add, 1 subtract, 2 compare, 3 logical right shift |
| set_flags_i | input | 1 | Update the stored flags at the next rising edge |
| shamt_i | input | 5 | Shift amount, 0 to 31 |
| result_o | output | 32 | Combinational result word |
| result_valid_o | output | 1 | Result is meant to be written (low for compare) |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry flag |
| flag_v_o | output | 1 | Stored overflow flag |

## Verification
Properties checked on every cycle:
- The unsigned a ≥ b carry rule after a subtract or compare.
- The carry out of a 33-bit sum after an add.
- Overflow against the sign-disagreement rule.
- N and Z against the previous result.
- Flags holding when updates are off, and V holding across shifts.
- A valid result never being flagged on a compare.

Only the bench scenarios can show the rest:
- The exact result words at the overflow boundaries 0x7FFFFFFF + 1 and 0x80000000 − 1.
- The carry a shift by one or by 31 produces.
- A zero-amount shift leaving carry alone after a preceding operation has set it.
- A reset arriving mid-run clearing flags that were set.

// File: rtl/asu_pkg.sv
package asu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_LSR = 2'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/asu_adder.sv
module asu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_in_o,
  output logic         c_out_o
);
  // low part: W-1 sum bits plus the carry into the top column
  logic [W-1:0] low;

  assign low        = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
  assign c_msb_in_o = low[W-1];
  assign sum_o      = {a_i[W-1] ^ b_i[W-1] ^ c_msb_in_o, low[W-2:0]};
  assign c_out_o    = (a_i[W-1] & b_i[W-1]) | (a_i[W-1] & c_msb_in_o) | (b_i[W-1] & c_msb_in_o);
endmodule

// File: rtl/asu_lsr.sv
module asu_lsr #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] sh_i,
  output logic [W-1:0]  res_o,
  output logic          last_o
);
  // extra guard bit below the LSB catches the last bit shifted out
  logic [W:0] stg [0:SW];

  assign stg[0] = {a_i, 1'b0};

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stg[k+1] = sh_i[k] ? (stg[k] >> (1 << k)) : stg[k];
  end

  assign res_o  = stg[SW][W:1];
  assign last_o = stg[SW][0];
endmodule

// File: rtl/asu_flag_reg.sv
module asu_flag_reg
  import asu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  assert_flags_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/asu_nzcv.sv
module asu_nzcv
  import asu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [1:0]    op_i,
  input  logic          set_flags_i,
  input  logic [SW-1:0] shamt_i,
  output logic [W-1:0]  result_o,
  output logic          result_valid_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_c_o,
  output logic          flag_v_o
);
  op_e          op;
  logic         is_add, is_lsr;
  logic [W-1:0] b_eff, sum, sh_res, res_int;
  logic         cin, c_msb_in, c_out, sh_last;
  flags_t       flags_d, flags_q;

  assign op     = op_e'(op_i);
  assign is_add = (op == OP_ADD);
  assign is_lsr = (op == OP_LSR);

  // subtract and compare: a + ~b + 1
  assign b_eff = is_add ? b_i : ~b_i;
  assign cin   = ~is_add;

  asu_adder #(.W(W)) u_adder (
    .a_i        (a_i),
    .b_i        (b_eff),
    .cin_i      (cin),
    .sum_o      (sum),
    .c_msb_in_o (c_msb_in),
    .c_out_o    (c_out)
  );

  asu_lsr #(.W(W), .SW(SW)) u_lsr (
    .a_i    (a_i),
    .sh_i   (shamt_i),
    .res_o  (sh_res),
    .last_o (sh_last)
  );

  assign res_int        = is_lsr ? sh_res : sum;
  assign result_o       = res_int;
  assign result_valid_o = (op != OP_CMP);

  always_comb begin
    flags_d.n = res_int[W-1];
    flags_d.z = ~|res_int;
    if (is_lsr) begin
      flags_d.c = (shamt_i != '0) ? sh_last : flags_q.c;
      flags_d.v = flags_q.v;
    end else begin
      flags_d.c = c_out;
      flags_d.v = c_msb_in ^ c_out;
    end
  end

  asu_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (set_flags_i),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;

  // sign-disagreement form of overflow, independent of the carry pair
  logic ovf_by_sign;
  assign ovf_by_sign = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);

  assert_add_carry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op == OP_ADD) |=>
      flag_c_o == (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}) > {1'b0, {W{1'b1}}}));

  assert_sub_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && (op == OP_SUB || op == OP_CMP)) |=>
      flag_c_o == ($past(a_i) >= $past(b_i)));

  assert_ovf_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && !is_lsr) |=> flag_v_o == $past(ovf_by_sign));

  assert_nz_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> (flag_n_o == $past(result_o[W-1])) && (flag_z_o == ($past(result_o) == '0)));

  assert_cmp_novalid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMP) |-> !result_valid_o);

  assert_lsr_keep_v_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && is_lsr) |=> flag_v_o == $past(flag_v_o));

  assert_sh0_keep_c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && is_lsr && shamt_i == '0) |=> $stable(flag_c_o));

  assert_sh0_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_lsr && shamt_i == '0) |-> result_o == a_i);
endmodule

// File: tb/asu_nzcv_tb.sv
module asu_nzcv_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [1:0]  op_i = '0;
  logic        set_flags_i = 1'b0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        result_valid_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int checks = 0;
  int fails  = 0;
  logic mn = 0, mz = 0, mc = 0, mv = 0;

  always #4 clk_i = ~clk_i;

  asu_nzcv u_dut (
    .clk_i, .rst_ni, .a_i, .b_i, .op_i, .set_flags_i, .shamt_i,
    .result_o, .result_valid_o, .flag_n_o, .flag_z_o, .flag_c_o, .flag_v_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk(tag, {28'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {28'd0, mn, mz, mc, mv});
  endtask

  // drive at negedge, check result mid-low phase, check flags after the edge
  task automatic run(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] sh, input logic sf, input string tag);
    longint ua, ub, sa, sb, r, sr;
    logic [31:0] er;
    logic ec, ev;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; shamt_i = sh; set_flags_i = sf;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ec = mc; ev = mv;
    case (op)
      2'd0: begin
        r = ua + ub; er = r[31:0]; ec = r[32];
        sr = sa + sb; ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      2'd1, 2'd2: begin
        r = ua - ub; er = r[31:0]; ec = (ua >= ub);
        sr = sa - sb; ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      default: begin
        er = a >> sh;
        ec = (sh == 0) ? mc : a[sh-1];
        ev = mv;
      end
    endcase
    #1;
    if (op != 2'd2) chk({tag, " result"}, result_o, er);
    chk("R5 valid", {31'd0, result_valid_o}, {31'd0, op != 2'd2});
    @(posedge clk_i);
    if (sf) begin
      mn = er[31]; mz = (er == 0); mc = ec; mv = ev;
    end
    #1;
    chk_flags({tag, " flags"});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_flags("R9 reset");
    rst_ni = 1'b1;

    run(2'd0, 32'h7FFF_FFFF, 32'h1, 0, 1, "R3 add ovf");
    run(2'd1, 32'h8000_0000, 32'h1, 0, 1, "R3 sub ovf");
    run(2'd1, 32'd32, 32'd9, 0, 1, "R2 32-9");
    run(2'd0, 32'hFFFF_FFFF, 32'h1, 0, 1, "R1 carry wrap Z");
    run(2'd2, 32'd5, 32'd5, 0, 1, "R5 cmp equal");
    run(2'd2, 32'd3, 32'd7, 0, 1, "R5 cmp lower");
    run(2'd0, 32'h8000_0000, 32'h8000_0000, 0, 1, "R3 neg ovf");
    run(2'd1, 32'h1234, 32'h1, 0, 0, "R8 hold");
    run(2'd3, 32'h0000_0007, 0, 5'd1, 1, "R6 lsr1");
    run(2'd3, 32'h8000_0000, 0, 5'd31, 1, "R6 lsr31");
    run(2'd3, 32'hC000_0000, 0, 5'd31, 1, "R6 lsr31 c1");
    run(2'd3, 32'hDEAD_BEEF, 0, 5'd0, 1, "R7 sh0");
    run(2'd1, 32'd1, 32'd2, 0, 1, "R2 borrow");
    run(2'd3, 32'h5, 0, 5'd0, 1, "R7 sh0 c0");
    run(2'd0, 32'h7FFF_FFFF, 32'h1, 0, 1, "R3 set v");
    run(2'd3, 32'h1, 0, 5'd1, 1, "R6 keep v zero");
    run(2'd0, 32'h5, 32'h6, 0, 0, "R8 hold add");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = 32'h8000_0000 ^ (ra & 32'hF);
      run(2'($urandom % 4), ra, rb, 5'($urandom % 32), 1'($urandom % 4 != 0), "R4 mixed");
    end

    @(negedge clk_i);
    rst_ni = 1'b0; mn = 0; mz = 0; mc = 0; mv = 0;
    #1;
    chk_flags("R9 mid reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule